// File: doc/BRIEF.md
# Edge-Strobe Write Burst Splitter

This block takes one write burst descriptor at a time, either incrementing or fixed-address, together with the byte strobes of the burst's opening beat and its closing beat. It turns the descriptor into a short list of downstream write commands. A boundary beat whose strobes are not all set is split off as a single-beat command that carries those strobes as byte enables. The other beats go out as one burst command with every byte enabled. The strobes of interior beats are never looked at, so the downstream side writes those words in full.

Commands leave in a fixed order: the optional head single, then the body burst when any beats are left, then the optional tail single. Each command is held until the downstream side accepts it with `cmd_ready`. A new descriptor is taken only when the block is idle.

The control is a four-state machine. ST_IDLE accepts a descriptor and moves to ST_HEAD, ST_BODY or ST_TAIL, whichever is the first command that is needed. ST_HEAD goes to ST_BODY, ST_TAIL or ST_IDLE when its command is accepted. ST_BODY goes to ST_TAIL or ST_IDLE when its command is accepted. ST_TAIL returns to ST_IDLE when its command is accepted. No state moves on while `cmd_ready` is low.

Top module: `edge_strobe_splitter`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_valid` is 0.
- R2: If `req_first_strb` is not all ones, the first command is a single (`cmd_single`=1, `cmd_beats`=1) at `req_addr`, with `cmd_be` equal to `req_first_strb`.
- R3: If the burst has two or more beats and `req_last_strb` is not all ones, the last command is a single with `cmd_be` equal to `req_last_strb`. For an incrementing burst its address is `req_addr` + `req_len`×BYTES.
- R4: The body command has `cmd_single`=0 and `cmd_be` all ones. Its `cmd_beats` equals (`req_len`+1) minus the number of beats split off. `req_len` encodes the beat count minus one, and `cmd_beats` is the plain beat count.
- R5: Commands come out in the order head single, body burst, tail single, with at most one of each. `req_ready` is 1 only when no command is pending, and it never overlaps `cmd_valid`.
- R6: A one-beat burst with partial strobes gives exactly one command, a single carrying `req_first_strb`.
- R7: For an incrementing burst (`req_fixed`=0) the body address is `req_addr`+BYTES when the head was split off, and `req_addr` otherwise.
- R8: For a fixed burst (`req_fixed`=1) every command uses `req_addr`.
- R9: When both boundary strobes are all ones, exactly one burst command of `req_len`+1 beats is issued at `req_addr`. A one-beat burst gives a burst command of 1 beat.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, every `cmd_*` output holds its value.
- R11: A two-beat burst with both boundary strobes partial gives two singles and no burst command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor present |
| req_ready | output | 1 | Block idle; descriptor taken when both are 1 |
| req_addr | input | ADDR_W | Start address of the burst |
| req_len | input | LEN_W | Beat count minus one |
| req_fixed | input | 1 | 1 = fixed address, 0 = incrementing |
| req_first_strb | input | BYTES | Strobes of the first beat |
| req_last_strb | input | BYTES | Strobes of the last beat |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_beats | output | LEN_W+1 | Beats in the command |
| cmd_be | output | BYTES | Byte enables of the command |
| cmd_single | output | 1 | 1 = single-beat split-off command |

## Verification
On every cycle the assertions check the following: a single always carries a partial enable with one beat, a burst always carries full enables, commands hold while stalled, two bursts never come back to back, idle and command-valid never overlap, a one-beat burst never splits off both boundary beats, and a fixed burst never moves its addresses. The addresses and beat counts each command should carry, the full order of the list, and the fact that nothing extra is issued can only be shown by the bench's directed bursts. Those bursts cover incrementing and fixed types, one-beat and maximum-length bursts, and a stalled downstream side.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } wsplit_state_e;
endpackage

// File: rtl/wsplit_classify.sv
module wsplit_classify #(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_fixed,
    input  logic [BYTES-1:0]  first_strb,
    input  logic [BYTES-1:0]  last_strb,
    output logic              peel_head,
    output logic              peel_tail,
    output logic [LEN_W:0]    body_beats,
    output logic [ADDR_W-1:0] body_addr,
    output logic [ADDR_W-1:0] tail_addr
);
    localparam int CNT_W  = LEN_W + 1;
    localparam int STEP_W = $clog2(BYTES);

    logic [CNT_W-1:0] total_beats;
    logic             multi_beat;

    always_comb begin
        total_beats = {1'b0, req_len} + CNT_W'(1);
        multi_beat  = (req_len != '0);
        peel_head   = ~&first_strb;
        // a one-beat burst only ever has a head
        peel_tail   = multi_beat && ~&last_strb;
        body_beats  = total_beats - CNT_W'(peel_head) - CNT_W'(peel_tail);
        if (req_fixed) begin
            body_addr = req_addr;
            tail_addr = req_addr;
        end else begin
            body_addr = peel_head ? req_addr + ADDR_W'(BYTES) : req_addr;
            tail_addr = req_addr + (ADDR_W'(req_len) << STEP_W);
        end
    end

    assert_one_beat_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len == '0) |-> !(peel_head && peel_tail));

    assert_fixed_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fixed) |-> (body_addr == req_addr && tail_addr == req_addr));
endmodule

// File: rtl/wsplit_seq.sv
module wsplit_seq
    import wsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTES-1:0]  first_strb,
    input  logic [BYTES-1:0]  last_strb,
    input  logic              peel_head,
    input  logic              peel_tail,
    input  logic [LEN_W:0]    body_beats,
    input  logic [ADDR_W-1:0] body_addr,
    input  logic [ADDR_W-1:0] tail_addr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W:0]    cmd_beats,
    output logic [BYTES-1:0]  cmd_be,
    output logic              cmd_single
);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [BYTES-1:0] ALL_BE = '1;

    wsplit_state_e state, state_nx;

    logic              head_q, tail_q, body_q;
    logic [CNT_W-1:0]  body_beats_q;
    logic [ADDR_W-1:0] head_addr_q, body_addr_q, tail_addr_q;
    logic [BYTES-1:0]  head_be_q, tail_be_q;
    logic              accept, fire;

    assign accept = req_valid && (state == ST_IDLE);
    assign fire   = cmd_valid && cmd_ready;

    // descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q       <= 1'b0;
            tail_q       <= 1'b0;
            body_q       <= 1'b0;
            body_beats_q <= '0;
            head_addr_q  <= '0;
            body_addr_q  <= '0;
            tail_addr_q  <= '0;
            head_be_q    <= '0;
            tail_be_q    <= '0;
        end else if (accept) begin
            head_q       <= peel_head;
            tail_q       <= peel_tail;
            body_q       <= (body_beats != '0);
            body_beats_q <= body_beats;
            head_addr_q  <= req_addr;
            body_addr_q  <= body_addr;
            tail_addr_q  <= tail_addr;
            head_be_q    <= first_strb;
            tail_be_q    <= last_strb;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) begin
                if (peel_head)              state_nx = ST_HEAD;
                else if (body_beats != '0)  state_nx = ST_BODY;
                else if (peel_tail)         state_nx = ST_TAIL;
            end
            ST_HEAD: if (fire) begin
                if (body_q)      state_nx = ST_BODY;
                else if (tail_q) state_nx = ST_TAIL;
                else             state_nx = ST_IDLE;
            end
            ST_BODY: if (fire) begin
                if (tail_q) state_nx = ST_TAIL;
                else        state_nx = ST_IDLE;
            end
            ST_TAIL: if (fire) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        cmd_valid  = 1'b0;
        cmd_addr   = '0;
        cmd_beats  = '0;
        cmd_be     = '0;
        cmd_single = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_HEAD: begin
                cmd_valid  = 1'b1;
                cmd_addr   = head_addr_q;
                cmd_beats  = CNT_W'(1);
                cmd_be     = head_be_q;
                cmd_single = 1'b1;
            end
            ST_BODY: begin
                cmd_valid = 1'b1;
                cmd_addr  = body_addr_q;
                cmd_beats = body_beats_q;
                cmd_be    = ALL_BE;
            end
            ST_TAIL: begin
                cmd_valid  = 1'b1;
                cmd_addr   = tail_addr_q;
                cmd_beats  = CNT_W'(1);
                cmd_be     = tail_be_q;
                cmd_single = 1'b1;
            end
            default: ;
        endcase
    end

    assert_idle_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && cmd_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
        $stable(cmd_beats) && $stable(cmd_be) && $stable(cmd_single)));

    assert_single_partial_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_single) |-> (cmd_be != ALL_BE && cmd_beats == CNT_W'(1)));

    assert_body_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_single) |-> (cmd_be == ALL_BE && cmd_beats != '0));

    assert_one_body_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_single) |=> !(cmd_valid && !cmd_single));
endmodule

// File: rtl/edge_strobe_splitter.sv
module edge_strobe_splitter #(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_fixed,
    input  logic [BYTES-1:0]  req_first_strb,
    input  logic [BYTES-1:0]  req_last_strb,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W:0]    cmd_beats,
    output logic [BYTES-1:0]  cmd_be,
    output logic              cmd_single
);
    logic              peel_head, peel_tail;
    logic [LEN_W:0]    body_beats;
    logic [ADDR_W-1:0] body_addr, tail_addr;

    wsplit_classify #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LEN_W(LEN_W)) u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_fixed  (req_fixed),
        .first_strb (req_first_strb),
        .last_strb  (req_last_strb),
        .peel_head  (peel_head),
        .peel_tail  (peel_tail),
        .body_beats (body_beats),
        .body_addr  (body_addr),
        .tail_addr  (tail_addr)
    );

    wsplit_seq #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .first_strb (req_first_strb),
        .last_strb  (req_last_strb),
        .peel_head  (peel_head),
        .peel_tail  (peel_tail),
        .body_beats (body_beats),
        .body_addr  (body_addr),
        .tail_addr  (tail_addr),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_addr   (cmd_addr),
        .cmd_beats  (cmd_beats),
        .cmd_be     (cmd_be),
        .cmd_single (cmd_single)
    );
endmodule

// File: tb/sim_edge_strobe_splitter.sv
`timescale 1ns/1ps
module sim_edge_strobe_splitter;
    localparam int ADDR_W = 32;
    localparam int BYTES  = 8;
    localparam int LEN_W  = 8;
    localparam logic [BYTES-1:0] FULL = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_fixed = 1'b0;
    logic [BYTES-1:0]  req_first_strb = '1;
    logic [BYTES-1:0]  req_last_strb = '1;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W:0]    cmd_beats;
    logic [BYTES-1:0]  cmd_be;
    logic              cmd_single;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [ADDR_W-1:0] e_addr   [3];
    logic [LEN_W:0]    e_beats  [3];
    logic [BYTES-1:0]  e_be     [3];
    logic              e_single [3];
    int                e_n;

    always #5 clk = ~clk;

    edge_strobe_splitter #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_fixed(req_fixed),
        .req_first_strb(req_first_strb), .req_last_strb(req_last_strb),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_beats(cmd_beats), .cmd_be(cmd_be), .cmd_single(cmd_single)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected command list, built from the requirements
    task automatic expect_list(input logic [ADDR_W-1:0] a, input int len, input bit fx,
                               input logic [BYTES-1:0] fs, input logic [BYTES-1:0] ls);
        int  beats = len + 1;
        bit  h = (fs != FULL);
        bit  t = (beats > 1) && (ls != FULL);
        int  mid = beats - int'(h) - int'(t);
        e_n = 0;
        if (h) begin
            e_addr[e_n] = a; e_beats[e_n] = 1; e_be[e_n] = fs; e_single[e_n] = 1; e_n++;
        end
        if (mid > 0) begin
            e_addr[e_n] = fx ? a : (h ? a + BYTES : a);
            e_beats[e_n] = (LEN_W+1)'(mid); e_be[e_n] = FULL; e_single[e_n] = 0; e_n++;
        end
        if (t) begin
            e_addr[e_n] = fx ? a : a + ADDR_W'(len * BYTES);
            e_beats[e_n] = 1; e_be[e_n] = ls; e_single[e_n] = 1; e_n++;
        end
    endtask

    task automatic run_burst(input string tag, input logic [ADDR_W-1:0] a, input int len,
                             input bit fx, input logic [BYTES-1:0] fs,
                             input logic [BYTES-1:0] ls, input bit stall);
        int got = 0;
        int cyc = 0;
        bit held = 0;
        logic [ADDR_W-1:0] h_addr;
        logic [LEN_W:0]    h_beats;
        logic [BYTES-1:0]  h_be;
        logic              h_single;
        expect_list(a, len, fx, fs, ls);
        @(negedge clk);
        check(req_ready == 1'b1, "R5", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len); req_fixed = fx;
        req_first_strb = fs; req_last_strb = ls;
        @(negedge clk);
        req_valid = 1'b0;
        while (got < e_n && cyc < 100) begin
            cmd_ready = stall ? cyc[0] : 1'b1;
            if (cmd_valid) begin
                if (held) begin
                    check(cmd_addr == h_addr && cmd_beats == h_beats && cmd_be == h_be &&
                          cmd_single == h_single, "R10", "held command changed",
                          {cmd_addr, cmd_be}, {h_addr, h_be});
                end
                if (cmd_ready) begin
                    check(cmd_addr == e_addr[got], tag, "cmd_addr", cmd_addr, e_addr[got]);
                    check(cmd_beats == e_beats[got], tag, "cmd_beats", cmd_beats, e_beats[got]);
                    check(cmd_be == e_be[got], tag, "cmd_be", cmd_be, e_be[got]);
                    check(cmd_single == e_single[got], tag, "cmd_single", cmd_single, e_single[got]);
                    got++;
                    held = 0;
                end else begin
                    held = 1; h_addr = cmd_addr; h_beats = cmd_beats; h_be = cmd_be;
                    h_single = cmd_single;
                end
            end
            cyc++;
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        check(got == e_n, tag, "command count", got, e_n);
        check(cmd_valid == 1'b0 && req_ready == 1'b1, "R5", "idle after list",
              {cmd_valid, req_ready}, 2'b01);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    endtask

    task automatic t_full_incr;      run_burst("R9", 32'h1000, 7, 0, FULL, FULL, 0);            endtask
    task automatic t_head_incr;      run_burst("R7", 32'h2000, 5, 0, 8'hF0, FULL, 0);           endtask
    task automatic t_head_only;      run_burst("R2", 32'h2100, 3, 0, 8'h0E, FULL, 0);           endtask
    task automatic t_tail_incr;      run_burst("R3", 32'h3000, 4, 0, FULL, 8'h0F, 0);           endtask
    task automatic t_both_incr;      run_burst("R5", 32'h4000, 9, 0, 8'hC0, 8'h03, 0);          endtask
    task automatic t_one_partial;    run_burst("R6", 32'h5000, 0, 0, 8'h3C, 8'h00, 0);          endtask
    task automatic t_one_full;       run_burst("R9", 32'h5100, 0, 0, FULL, 8'h01, 0);           endtask
    task automatic t_fixed_both;     run_burst("R8", 32'h6000, 6, 1, 8'h80, 8'h7F, 0);          endtask
    task automatic t_two_both;       run_burst("R11", 32'h7000, 1, 0, 8'h01, 8'h80, 0);         endtask
    task automatic t_stall;          run_burst("R10", 32'h8000, 3, 0, 8'hFE, 8'h7F, 1);         endtask
    task automatic t_long;           run_burst("R4", 32'h9000, 255, 0, 8'h0F, 8'hF0, 1);        endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_incr();
        t_head_incr();
        t_head_only();
        t_tail_incr();
        t_both_incr();
        t_one_partial();
        t_one_full();
        t_fixed_both();
        t_two_both();
        t_stall();
        t_long();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule